// File: doc/BRIEF.md
# System controller register file

This block is the word-addressed control and status register set of a small system controller. A bus master issues one request per cycle: a byte address, a four-bit byte-enable, a write flag and write data. Bits [1:0] of the address are discarded, so the rest of the address selects a 32-bit word. Only requests with all four byte lanes enabled are accepted. Any other request is dropped without a trace.

The map holds general-purpose output and interrupt-enable words, two timer groups (control, compare and counter words), a scratch word, a lock flag that sets itself on any write, and read-only identity words (strap value, clock frequency, capability mask, system identifier). Some words have side effects. A write of the power-off command to the configuration command word pulses a shutdown request. A write to the system identifier pulses a reset request and leaves the identifier unchanged. The timer words are brought out on ports for an external timer datapath.

A read returns its data one cycle after the request. Accepted accesses to unmapped words raise a one-cycle error flag.

Top module: `sysctl_regs`

## Requirements
- R1: After reset the words read as follows. Index 0 (strap) reads 0x00000001. Index 16 (configuration) reads 0x00000001, bit 0 being the ready bit. Index 29 reads 0x04C4B400 (80,000,000). Index 30 reads 0x00000000. Index 31 reads 0x10014D31. Every other mapped word reads 0, and all outputs are 0.
- R2: Indices 1 (output), 2 (interrupt enable) and 20 (scratch) store the full written word and read it back. So do indices 4/5/6 (timer 0 control/compare/counter) and 8/9/10 (timer 1). Index 1 drives gpio_out, index 2 drives gpio_irq_en, and timer t appears on bits [32t+31:32t] of tmr_ctrl, tmr_compare and tmr_count.
- R3: A read request accepted at a clock edge makes rd_valid high and rd_data carry the word after that edge, for exactly one cycle. When there is no read, rd_valid is low and rd_data is 0.
- R4: A request whose byte-enable is not 4'b1111 changes no word and produces no rd_valid, no error and no request pulse.
- R5: Any write to index 21 sets the lock word to 1 whatever the data. It stays 1 until reset.
- R6: A write to index 16 whose bits [15:0] equal 0x000E gives a one-cycle shutdown_req pulse after the edge. Other values give none. Index 16 always reads 0x00000001.
- R7: Any write to index 31 gives a one-cycle reset_req pulse after the edge, and the identifier reads back unchanged.
- R8: Writes to indices 0, 29 and 30 are ignored.
- R9: Any accepted access to an index outside {0,1,2,4,5,6,8,9,10,16,20,21,29,30,31} raises acc_err for one cycle. A read there returns 0, and a write there changes nothing.
- R10: Address bits [1:0] do not affect which word is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | 4 | Byte enables; only 4'b1111 is accepted |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read response strobe |
| gpio_out | output | 32 | General-purpose output word |
| gpio_irq_en | output | 32 | General-purpose interrupt-enable word |
| tmr_ctrl | output | 32*NUM_TIMERS | Timer control words |
| tmr_compare | output | 32*NUM_TIMERS | Timer compare words |
| tmr_count | output | 32*NUM_TIMERS | Timer counter words |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reset_req | output | 1 | One-cycle system reset request |
| acc_err | output | 1 | One-cycle unmapped-access flag |

## Verification
The bench writes data to the lock word, including zero. A design that stored the data bit there would read back 0 instead of the sticky 1. It sends command values that share the low half with the power-off code but differ in the upper half, and values that miss it by one. A decoder that compared all 32 bits would miss the first kind, and a loose mask would fire on the second. It issues partial-lane writes to stored words and accesses with nonzero low address bits. It also writes to the identity words and to the holes and far end of the map. A design that leaked any of these would change a read-back value or raise a stray pulse or error. A reset in the middle of the run checks that the lock and stored words return to their defaults.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int WORD_W      = 32;
    localparam int BE_W        = WORD_W / 8;
    localparam int IX_GPIO_IN  = 0;
    localparam int IX_GPIO_OUT = 1;
    localparam int IX_IRQ_EN   = 2;
    localparam int IX_CFG      = 16;
    localparam int IX_SCRATCH  = 20;
    localparam int IX_LOCK     = 21;
    localparam int IX_FREQ     = 29;
    localparam int IX_CAPS     = 30;
    localparam int IX_SYSID    = 31;
    localparam int TMR_FIRST   = 4;
    localparam int TMR_STRIDE  = 4;
    localparam int TMR_FIELDS  = 3;
    localparam logic [15:0]       SHUTDOWN_CODE = 16'h000E;
    localparam logic [WORD_W-1:0] CFG_READY     = 32'h0000_0001;

    typedef struct packed {
        logic [WORD_W-1:0] gpio_out;
        logic [WORD_W-1:0] irq_en;
        logic [WORD_W-1:0] scratch;
        logic              lock;
        logic [WORD_W-1:0] rdata;
        logic              rvalid;
        logic              shut;
        logic              rreq;
        logic              err;
    } ctl_state_t;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int NUM_TIMERS = 2,
    localparam int IDX_W     = ADDR_W - 2
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    output logic [IDX_W-1:0]  idx,
    output logic              wr_ok,
    output logic              rd_ok,
    output logic              mapped
);
    logic acc_ok;
    logic unused_lo;

    assign unused_lo = ^req_addr[1:0];
    assign idx       = req_addr[ADDR_W-1:2];
    assign acc_ok    = req_valid && (&req_be);
    assign wr_ok     = acc_ok && req_write;
    assign rd_ok     = acc_ok && !req_write;

    always_comb begin
        case (int'(idx))
            IX_GPIO_IN, IX_GPIO_OUT, IX_IRQ_EN, IX_CFG, IX_SCRATCH,
            IX_LOCK, IX_FREQ, IX_CAPS, IX_SYSID: mapped = 1'b1;
            default: mapped = 1'b0;
        endcase
        for (int t = 0; t < NUM_TIMERS; t++) begin
            for (int k = 0; k < TMR_FIELDS; k++) begin
                if (int'(idx) == TMR_FIRST + t * TMR_STRIDE + k) mapped = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sysctl_timer_bank.sv
module sysctl_timer_bank
    import sysctl_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int BASE  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] ctrl,
    output logic [WORD_W-1:0] cmp,
    output logic [WORD_W-1:0] cnt,
    output logic [WORD_W-1:0] rd_val
);
    logic [TMR_FIELDS-1:0][WORD_W-1:0] fld_d, fld_q;

    always_comb begin
        fld_d  = fld_q;
        rd_val = '0;
        for (int k = 0; k < TMR_FIELDS; k++) begin
            if (int'(idx) == BASE + k) begin
                rd_val = fld_q[k];
                if (wr_ok) fld_d[k] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fld_q <= '0;
        else        fld_q <= fld_d;
    end

    assign ctrl = fld_q[0];
    assign cmp  = fld_q[1];
    assign cnt  = fld_q[2];

    AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ok |=> $stable(fld_q)); // R2
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                NUM_TIMERS = 2,
    parameter logic [WORD_W-1:0] STRAP_VAL  = 32'h0000_0001,
    parameter logic [WORD_W-1:0] CLK_HZ     = 32'd80_000_000,
    parameter logic [WORD_W-1:0] CAPS_VAL   = 32'h0000_0000,
    parameter logic [WORD_W-1:0] SYS_ID     = 32'h1001_4D31
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [3:0]                   req_be,
    input  logic [31:0]                  req_wdata,
    output logic [31:0]                  rd_data,
    output logic                         rd_valid,
    output logic [31:0]                  gpio_out,
    output logic [31:0]                  gpio_irq_en,
    output logic [32*NUM_TIMERS-1:0]     tmr_ctrl,
    output logic [32*NUM_TIMERS-1:0]     tmr_compare,
    output logic [32*NUM_TIMERS-1:0]     tmr_count,
    output logic                         shutdown_req,
    output logic                         reset_req,
    output logic                         acc_err
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  idx;
    logic              wr_ok, rd_ok, mapped;
    logic [WORD_W-1:0] tmr_rd [NUM_TIMERS];
    logic [WORD_W-1:0] tmr_rd_any;
    logic [WORD_W-1:0] rd_mux;
    ctl_state_t        st_d, st_q;

    sysctl_decode #(.ADDR_W(ADDR_W), .NUM_TIMERS(NUM_TIMERS)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .idx       (idx),
        .wr_ok     (wr_ok),
        .rd_ok     (rd_ok),
        .mapped    (mapped)
    );

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
        sysctl_timer_bank #(.IDX_W(IDX_W), .BASE(TMR_FIRST + t * TMR_STRIDE)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_ok  (wr_ok),
            .idx    (idx),
            .wdata  (req_wdata),
            .ctrl   (tmr_ctrl[t*WORD_W +: WORD_W]),
            .cmp    (tmr_compare[t*WORD_W +: WORD_W]),
            .cnt    (tmr_count[t*WORD_W +: WORD_W]),
            .rd_val (tmr_rd[t])
        );
    end

    always_comb begin
        tmr_rd_any = '0;
        for (int t = 0; t < NUM_TIMERS; t++) tmr_rd_any = tmr_rd_any | tmr_rd[t];
    end

    always_comb begin
        case (int'(idx))
            IX_GPIO_IN:  rd_mux = STRAP_VAL;
            IX_GPIO_OUT: rd_mux = st_q.gpio_out;
            IX_IRQ_EN:   rd_mux = st_q.irq_en;
            IX_CFG:      rd_mux = CFG_READY;
            IX_SCRATCH:  rd_mux = st_q.scratch;
            IX_LOCK:     rd_mux = {{(WORD_W-1){1'b0}}, st_q.lock};
            IX_FREQ:     rd_mux = CLK_HZ;
            IX_CAPS:     rd_mux = CAPS_VAL;
            IX_SYSID:    rd_mux = SYS_ID;
            default:     rd_mux = tmr_rd_any;
        endcase
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        st_d.rdata  = '0;
        st_d.shut   = 1'b0;
        st_d.rreq   = 1'b0;
        st_d.err    = 1'b0;
        if (rd_ok) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = mapped ? rd_mux : '0;
            st_d.err    = !mapped;
        end
        if (wr_ok) begin
            st_d.err = !mapped;
            case (int'(idx))
                IX_GPIO_OUT: st_d.gpio_out = req_wdata;
                IX_IRQ_EN:   st_d.irq_en   = req_wdata;
                IX_SCRATCH:  st_d.scratch  = req_wdata;
                IX_LOCK:     st_d.lock     = 1'b1;
                IX_CFG:      st_d.shut     = (req_wdata[15:0] == SHUTDOWN_CODE);
                IX_SYSID:    st_d.rreq     = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data      = st_q.rdata;
    assign rd_valid     = st_q.rvalid;
    assign gpio_out     = st_q.gpio_out;
    assign gpio_irq_en  = st_q.irq_en;
    assign shutdown_req = st_q.shut;
    assign reset_req    = st_q.rreq;
    assign acc_err      = st_q.err;

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> st_q.lock); // R5
    AST_RD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write && (&req_be))); // R3
    AST_NO_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0)); // R3
    AST_PARTIAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(&req_be)) |=> (!rd_valid && !acc_err && !shutdown_req && !reset_req)); // R4
    AST_SHUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> $past(req_valid && req_write && (&req_be) && (req_wdata[15:0] == SHUTDOWN_CODE))); // R6
    AST_RREQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(req_valid && req_write && (&req_be))); // R7
    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_err && rd_valid) |-> (rd_data == '0)); // R9
endmodule

// File: tb/sim_sysctl_regs.sv
`timescale 1ns/1ps
module sim_sysctl_regs;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr  = '0;
    logic [3:0]  req_be    = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [31:0] gpio_out, gpio_irq_en;
    logic [63:0] tmr_ctrl, tmr_compare, tmr_count;
    logic        shutdown_req, reset_req, acc_err;

    int    checks = 0;
    int    errors = 0;
    bit    started = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    sysctl_regs u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .gpio_out(gpio_out),
        .gpio_irq_en(gpio_irq_en), .tmr_ctrl(tmr_ctrl), .tmr_compare(tmr_compare),
        .tmr_count(tmr_count), .shutdown_req(shutdown_req), .reset_req(reset_req),
        .acc_err(acc_err)
    );

    // behavioural reference model
    logic [31:0] m_word [0:63];
    logic        m_lock;
    logic [31:0] e_rdata;
    logic        e_rvalid, e_shut, e_rreq, e_err;

    function automatic bit m_mapped(int i);
        return i inside {0, 1, 2, 4, 5, 6, 8, 9, 10, 16, 20, 21, 29, 30, 31};
    endfunction

    function automatic logic [31:0] m_read(int i);
        case (i)
            0:  return 32'h0000_0001;
            16: return 32'h0000_0001;
            21: return {31'b0, m_lock};
            29: return 32'd80_000_000;
            30: return 32'h0;
            31: return 32'h1001_4D31;
            default: return m_mapped(i) ? m_word[i] : 32'h0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        e_rvalid = 0; e_rdata = 0; e_shut = 0; e_rreq = 0; e_err = 0;
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) m_word[i] = 0;
            m_lock = 0;
        end else if (req_valid && req_be == 4'hF) begin
            int i;
            i = int'(req_addr >> 2);
            e_err = !m_mapped(i);
            if (!req_write) begin
                e_rvalid = 1;
                e_rdata  = m_read(i);
            end else begin
                if (i inside {1, 2, 4, 5, 6, 8, 9, 10, 20}) m_word[i] = req_wdata;
                if (i == 21) m_lock = 1;
                if (i == 16 && req_wdata[15:0] == 16'h000E) e_shut = 1;
                if (i == 31) e_rreq = 1;
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            chk({"R3 valid ", cur_req}, {31'b0, rd_valid}, {31'b0, e_rvalid});
            chk({"rdata ", cur_req}, rd_data, e_rdata);
            chk({"R6 shutdown ", cur_req}, {31'b0, shutdown_req}, {31'b0, e_shut});
            chk({"R7 reset_req ", cur_req}, {31'b0, reset_req}, {31'b0, e_rreq});
            chk({"R9 err ", cur_req}, {31'b0, acc_err}, {31'b0, e_err});
            chk({"R2 gpio_out ", cur_req}, gpio_out, m_word[1]);
            chk({"R2 irq_en ", cur_req}, gpio_irq_en, m_word[2]);
            chk({"R2 tmr_ctrl ", cur_req}, tmr_ctrl, {m_word[8], m_word[4]});
            chk({"R2 tmr_compare ", cur_req}, tmr_compare, {m_word[9], m_word[5]});
            chk({"R2 tmr_count ", cur_req}, tmr_count, {m_word[10], m_word[6]});
        end
    end

    task automatic acc(bit wr, logic [7:0] a, logic [3:0] be, logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
    endtask
    task automatic wr(logic [7:0] a, logic [31:0] d); acc(1, a, 4'hF, d); endtask
    task automatic rd(logic [7:0] a); acc(0, a, 4'hF, 32'h0); endtask
    task automatic idle();
        @(negedge clk);
        req_valid = 0; req_be = 0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 0;
        repeat (2) @(negedge clk);
        started = 1;
        @(negedge clk);
        rst_n = 1;
        cur_req = "R1";
        foreach (m_word[i]) if (i < 32) rd(8'(i * 4));
        idle();
        cur_req = "R2";
        wr(8'h04, 32'hA5A5_0F0F); wr(8'h08, 32'hFFFF_FFFF); wr(8'h50, 32'h1234_5678);
        wr(8'h10, 32'h0000_0003); wr(8'h14, 32'hDEAD_BEEF); wr(8'h18, 32'h0000_0010);
        wr(8'h20, 32'h0000_0001); wr(8'h24, 32'h8000_0000); wr(8'h28, 32'h5555_AAAA);
        for (int i = 0; i < 11; i++) rd(8'(i * 4));
        rd(8'h50);
        cur_req = "R10";
        wr(8'h07, 32'h0BAD_F00D); rd(8'h05); rd(8'h26); wr(8'h53, 32'h0000_00FF); rd(8'h52);
        cur_req = "R4";
        acc(1, 8'h50, 4'b0111, 32'h1111_1111); acc(1, 8'h04, 4'b1000, 32'h2222_2222);
        acc(0, 8'h50, 4'b0001, 32'h0); acc(1, 8'h38, 4'b1110, 32'h0000_000E);
        acc(1, 8'h7C, 4'b0011, 32'h0); acc(1, 8'h54, 4'b0000, 32'h0);
        rd(8'h50); rd(8'h04); rd(8'h54);
        cur_req = "R5";
        rd(8'h54); wr(8'h54, 32'h0); rd(8'h54); wr(8'h54, 32'hFFFF_FFFE); idle(); rd(8'h54);
        cur_req = "R6";
        wr(8'h40, 32'h0000_000E); idle(); wr(8'h40, 32'hABCD_000E); wr(8'h40, 32'h0001_000E);
        wr(8'h40, 32'h0000_000F); wr(8'h40, 32'h000E_0000); wr(8'h40, 32'h0000_800E);
        rd(8'h40);
        cur_req = "R7";
        wr(8'h7C, 32'h0); idle(); wr(8'h7C, 32'hFFFF_FFFF); rd(8'h7C);
        cur_req = "R8";
        wr(8'h00, 32'hFFFF_FFFF); wr(8'h74, 32'h1); wr(8'h78, 32'hFFFF_FFFF);
        rd(8'h00); rd(8'h74); rd(8'h78);
        cur_req = "R9";
        rd(8'h0C); rd(8'h44); rd(8'h6C); rd(8'hA0); rd(8'hFC);
        wr(8'h0C, 32'hCAFE_CAFE); wr(8'h30, 32'h1); wr(8'hFC, 32'h0000_000E);
        rd(8'h0C); rd(8'h30); rd(8'hFC); idle();
        cur_req = "R1";
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        rd(8'h54); rd(8'h50); rd(8'h04); rd(8'h10); rd(8'h7C); rd(8'h40);
        idle(); idle();
        finish_run();
    end
endmodule